// File: doc/BRIEF.md
# DRAM Refresh Request Controller

This block decides when an external DRAM or SDRAM gets refreshed and tells the bus sequencer about it. A small control register holds two live bits, a refresh enable and a refresh mode. A prescaled up-counter is compared against a programmable constant. Each time the two match, the counter wraps and a compare-match flag is set. When periodic refresh is selected, that match also posts one pending refresh request.

In periodic mode, a pending request is serviced by one auto-refresh (CAS-before-RAS) command strobe. If an external bus cycle is running at that moment, the controller pulses an abort to end that cycle. In self-refresh mode, the controller first waits for any running bus cycle to finish. It then issues a self-refresh entry strobe and holds the memory there, dropping every request the timer produces. Clearing the mode bit or the enable bit while in self-refresh produces exactly one exit strobe. While any refresh command or self-refresh occupies the memory, the controller raises a busy output and withholds grants to new accesses. The timer keeps running with refresh disabled, so it also works as a plain interval timer.

Top module: `rfsh_ctrl`

## Requirements
- R1: After reset, the control readback is 0, the compare-match flag is 0, and every command strobe, `bus_abort`, `bus_busy` and `acc_grant` are 0.
- R2: `cfg_wdata[2]` is refresh enable and `cfg_wdata[1]` is refresh mode. `cfg_rdata` returns them in the same positions. `cfg_rdata[0]` always reads 0, whatever value was written.
- R3: A write of the compare constant clears the counter and prescaler. The prescaler divides the clock by PRESC_DIV. `cmp_flag` rises at the PRESC_DIV*(cmp+1)-th clock edge after the write edge. This happens whether or not refresh is enabled. `cmp_flag_clr` clears the flag.
- R4: With enable at 0, no refresh command strobe of any kind is issued.
- R5: With enable 1 and mode 0, each compare match yields exactly one `cmd_auto` pulse. Consecutive pulses are PRESC_DIV*(cmp+1) cycles apart.
- R6: If `bus_cycle_active` is high when an auto-refresh starts, `bus_abort` pulses in the same cycle as `cmd_auto`. If `bus_cycle_active` is low, `bus_abort` stays 0.
- R7: Each auto-refresh holds `bus_busy` high for exactly REF_CLKS cycles, and `acc_grant` stays 0 during that time. When the controller is idle, `acc_grant` follows `acc_req` one cycle later.
- R8: With enable 1 and mode 1, `cmd_sr_enter` is not issued while `bus_cycle_active` is high. It pulses once, one cycle after the clock edge at which `bus_cycle_active` is first seen low.
- R9: While in self-refresh, timer matches cause no `cmd_auto`, and `bus_busy` and `in_self_refresh` stay high.
- R10: Clearing either mode or enable while in self-refresh gives exactly one `cmd_sr_exit` pulse, two cycles after the configuration write edge. It is followed by REF_CLKS busy cycles, after which the controller goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | Control write data: [2] enable, [1] mode, [0] reserved |
| cfg_rdata | output | 3 | Control readback, bit 0 always 0 |
| cmp_we | input | 1 | Compare constant write strobe (also clears the counter) |
| cmp_wdata | input | CNT_W | Compare constant |
| cmp_flag_clr | input | 1 | Clears the compare-match flag |
| cmp_flag | output | 1 | Compare-match flag |
| bus_cycle_active | input | 1 | An external bus cycle is in progress |
| acc_req | input | 1 | New access request from the sequencer |
| acc_grant | output | 1 | Access granted (memory not occupied) |
| bus_busy | output | 1 | Memory occupied by refresh or self-refresh |
| bus_abort | output | 1 | End the running bus cycle now |
| cmd_auto | output | 1 | Auto-refresh command strobe |
| cmd_sr_enter | output | 1 | Self-refresh entry command strobe |
| cmd_sr_exit | output | 1 | Self-refresh exit command strobe |
| in_self_refresh | output | 1 | Memory is held in self-refresh |

## Verification
The timer has three register stages on its path: the counter, the registered match pulse and the pending request. Because of this, interval results are measured as the spacing between strobes or as the edge count from a compare write to the flag, never as a fixed offset from a match. A configuration write lands at its edge, and the sequencer reacts at the next edge. Entry and exit strobes are therefore sampled at the second falling clock after the write, and an entry strobe at the first falling clock after `bus_cycle_active` is dropped. All inputs change and all outputs are sampled on the falling clock. Busy windows are counted sample by sample against REF_CLKS.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_AUTO   = 3'd1,
    ST_SR     = 3'd2,
    ST_SR_EXIT = 3'd3
  } rfsh_state_t;
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int CNT_W     = 8,
  parameter int PRESC_DIV = 4,
  parameter int CMP_RST   = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             flag_clr,
  output logic             match,
  output logic             flag
);
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0]    pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic             tick;
  logic             hit;

  assign tick = (pre_q == PRE_LAST);
  assign hit  = tick && (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
      cmp_q <= CNT_W'(CMP_RST);
      match <= 1'b0;
    end else if (cmp_we) begin
      pre_q <= '0;
      cnt_q <= '0;
      cmp_q <= cmp_wdata;
      match <= 1'b0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      match <= hit;
      if (hit)       cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int REF_CLKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic mode,
  input  logic match,
  input  logic bus_cycle_active,
  input  logic acc_req,
  output logic acc_grant,
  output logic bus_busy,
  output logic bus_abort,
  output logic cmd_auto,
  output logic cmd_sr_enter,
  output logic cmd_sr_exit,
  output logic in_sr
);
  localparam int OW = (REF_CLKS > 1) ? $clog2(REF_CLKS) : 1;
  localparam logic [OW-1:0] OCC_LOAD = OW'(REF_CLKS - 1);

  rfsh_state_t st_q, st_d;
  logic [OW-1:0] occ_q;
  logic pend_q;
  logic periodic, self_sel;
  logic go_auto, go_enter, go_exit;

  assign periodic = en && !mode;
  assign self_sel = en && mode;

  always_comb begin
    st_d     = st_q;
    go_auto  = 1'b0;
    go_enter = 1'b0;
    go_exit  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (self_sel && !bus_cycle_active) begin
          st_d = ST_SR;  go_enter = 1'b1;
        end else if (periodic && pend_q) begin
          st_d = ST_AUTO; go_auto = 1'b1;
        end
      end
      ST_AUTO:    if (occ_q == '0) st_d = ST_IDLE;
      ST_SR: begin
        if (!self_sel) begin
          st_d = ST_SR_EXIT; go_exit = 1'b1;
        end
      end
      ST_SR_EXIT: if (occ_q == '0) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             pend_q <= 1'b0;
    else if (!periodic)  pend_q <= 1'b0;
    else if (match)      pend_q <= 1'b1;
    else if (go_auto)    pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      occ_q        <= '0;
      cmd_auto     <= 1'b0;
      cmd_sr_enter <= 1'b0;
      cmd_sr_exit  <= 1'b0;
      bus_abort    <= 1'b0;
      bus_busy     <= 1'b0;
      acc_grant    <= 1'b0;
      in_sr        <= 1'b0;
    end else begin
      st_q         <= st_d;
      if (go_auto || go_exit) occ_q <= OCC_LOAD;
      else if (occ_q != '0)   occ_q <= occ_q - 1'b1;
      cmd_auto     <= go_auto;
      cmd_sr_enter <= go_enter;
      cmd_sr_exit  <= go_exit;
      bus_abort    <= go_auto && bus_cycle_active;
      bus_busy     <= (st_d != ST_IDLE);
      acc_grant    <= acc_req && (st_d == ST_IDLE);
      in_sr        <= (st_d == ST_SR);
    end
  end
endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl #(
  parameter int CNT_W     = 8,
  parameter int PRESC_DIV = 4,
  parameter int CMP_RST   = 255,
  parameter int REF_CLKS  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_wdata,
  output logic [2:0]       cfg_rdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             cmp_flag_clr,
  output logic             cmp_flag,
  input  logic             bus_cycle_active,
  input  logic             acc_req,
  output logic             acc_grant,
  output logic             bus_busy,
  output logic             bus_abort,
  output logic             cmd_auto,
  output logic             cmd_sr_enter,
  output logic             cmd_sr_exit,
  output logic             in_self_refresh
);
  logic en_q, mode_q, match;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
    end else if (cfg_we) begin
      en_q   <= cfg_wdata[2];
      mode_q <= cfg_wdata[1];
    end
  end

  assign cfg_rdata = {en_q, mode_q, 1'b0};

  rfsh_timer #(.CNT_W(CNT_W), .PRESC_DIV(PRESC_DIV), .CMP_RST(CMP_RST)) timer_i (
    .clk(clk), .rst(rst), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .flag_clr(cmp_flag_clr), .match(match), .flag(cmp_flag)
  );

  rfsh_seq #(.REF_CLKS(REF_CLKS)) seq_i (
    .clk(clk), .rst(rst), .en(en_q), .mode(mode_q), .match(match),
    .bus_cycle_active(bus_cycle_active), .acc_req(acc_req),
    .acc_grant(acc_grant), .bus_busy(bus_busy), .bus_abort(bus_abort),
    .cmd_auto(cmd_auto), .cmd_sr_enter(cmd_sr_enter),
    .cmd_sr_exit(cmd_sr_exit), .in_sr(in_self_refresh)
  );
endmodule

// File: rtl/rfsh_ctrl_chk.sv
module rfsh_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cfg_rdata,
  input logic       bus_cycle_active,
  input logic       acc_grant,
  input logic       bus_busy,
  input logic       bus_abort,
  input logic       cmd_auto,
  input logic       cmd_sr_enter,
  input logic       cmd_sr_exit,
  input logic       in_self_refresh
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst) !cfg_rdata[0]); // R2
  AST_NO_CMD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (cmd_auto || cmd_sr_enter) |-> $past(cfg_rdata[2])); // R4
  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_auto, cmd_sr_enter, cmd_sr_exit})); // R5
  AST_ABORT_WITH_AUTO: assert property (@(posedge clk) disable iff (rst)
    bus_abort |-> cmd_auto); // R6
  AST_GRANT_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    acc_grant |-> !bus_busy); // R7
  AST_SR_ENTER_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_sr_enter |-> !$past(bus_cycle_active)); // R8
  AST_SR_NO_AUTO: assert property (@(posedge clk) disable iff (rst)
    in_self_refresh |-> (!cmd_auto && bus_busy)); // R9
  AST_EXIT_FROM_SR: assert property (@(posedge clk) disable iff (rst)
    cmd_sr_exit |-> $past(in_self_refresh)); // R10
endmodule

bind rfsh_ctrl rfsh_ctrl_chk chk_i (.*);

// File: tb/rfsh_ctrl_tb_top.sv
module rfsh_ctrl_tb_top;
  localparam int CNT_W = 8;
  localparam int PRESC = 4;
  localparam int RCL   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic [2:0] cfg_rdata;
  logic cmp_we = 1'b0;
  logic [CNT_W-1:0] cmp_wdata = '0;
  logic cmp_flag_clr = 1'b0;
  logic cmp_flag;
  logic bus_cycle_active = 1'b0;
  logic acc_req = 1'b0;
  logic acc_grant, bus_busy, bus_abort, cmd_auto, cmd_sr_enter, cmd_sr_exit, in_sr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rfsh_ctrl #(.CNT_W(CNT_W), .PRESC_DIV(PRESC), .CMP_RST(255), .REF_CLKS(RCL)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cmp_flag_clr(cmp_flag_clr), .cmp_flag(cmp_flag),
    .bus_cycle_active(bus_cycle_active), .acc_req(acc_req), .acc_grant(acc_grant),
    .bus_busy(bus_busy), .bus_abort(bus_abort), .cmd_auto(cmd_auto),
    .cmd_sr_enter(cmd_sr_enter), .cmd_sr_exit(cmd_sr_exit), .in_self_refresh(in_sr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_cmp(input int v);
    @(negedge clk); cmp_we = 1'b1; cmp_wdata = CNT_W'(v); cmp_flag_clr = 1'b1;
    @(negedge clk); cmp_we = 1'b0; cmp_flag_clr = 1'b0;
  endtask

  // waits until cmd_auto is seen; returns samples taken, or -1 after lim
  task automatic wait_auto(input int lim, output int n);
    n = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (cmd_auto) begin n = i; break; end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int n, cnt, busy_n, grant_bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 3'b000 && !cmp_flag, "R1", {cfg_rdata, cmp_flag}, 0);
    chk({cmd_auto, cmd_sr_enter, cmd_sr_exit, bus_abort, bus_busy, acc_grant} == 6'b0,
        "R1", {cmd_auto, cmd_sr_enter, cmd_sr_exit, bus_abort, bus_busy, acc_grant}, 0);

    // R2 reserved bit: enable=0 so no refresh starts
    wr_cfg(3'b011);
    chk(cfg_rdata == 3'b010, "R2", cfg_rdata, 2);
    wr_cfg(3'b001);
    chk(cfg_rdata == 3'b000, "R2", cfg_rdata, 0);

    // R3 interval timer sweep with refresh disabled; R4 no commands
    for (int c = 0; c < 6; c++) begin
      wr_cmp(c);
      n = -1; cnt = 0;
      for (int i = 1; i <= PRESC * (c + 1) + 4; i++) begin
        @(negedge clk);
        if (cmd_auto || cmd_sr_enter || cmd_sr_exit) cnt++;
        if (cmp_flag && n < 0) n = i;
      end
      chk(n == PRESC * (c + 1), "R3", n, PRESC * (c + 1));
      chk(cnt == 0, "R4", cnt, 0);
    end
    @(negedge clk); cmp_flag_clr = 1'b1;
    @(negedge clk); cmp_flag_clr = 1'b0;
    chk(!cmp_flag, "R3", cmp_flag, 0);

    // R5 periodic spacing sweep; R7 busy length and grant withheld
    acc_req = 1'b1;
    wr_cfg(3'b100);
    for (int c = 1; c < 6; c++) begin
      wr_cmp(c);
      wait_auto(200, n);
      wait_auto(200, n);
      chk(n == PRESC * (c + 1), "R5", n, PRESC * (c + 1));
      busy_n = 0; grant_bad = 0;
      for (int i = 0; i < PRESC * (c + 1) - 1; i++) begin
        if (bus_busy) busy_n++;
        if (bus_busy && acc_grant) grant_bad++;
        @(negedge clk);
      end
      chk(busy_n == RCL, "R7", busy_n, RCL);
      chk(grant_bad == 0, "R7", grant_bad, 0);
      chk(acc_grant && !bus_busy, "R7", acc_grant, 1);
    end

    // R6 abort only when a bus cycle is running
    wr_cmp(2);
    wait_auto(200, n);
    chk(!bus_abort, "R6", bus_abort, 0);
    @(negedge clk); bus_cycle_active = 1'b1;
    wait_auto(200, n);
    chk(bus_abort, "R6", bus_abort, 1);
    @(negedge clk);
    chk(!bus_abort, "R6", bus_abort, 0);

    // R8 self-refresh entry waits for the bus cycle
    wr_cfg(3'b000);
    repeat (6) @(negedge clk);
    wr_cfg(3'b110);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cmd_sr_enter) cnt++;
    end
    chk(cnt == 0, "R8", cnt, 0);
    bus_cycle_active = 1'b0;
    @(negedge clk);
    chk(cmd_sr_enter, "R8", cmd_sr_enter, 1);
    @(negedge clk);
    chk(!cmd_sr_enter && in_sr, "R8", cmd_sr_enter, 0);

    // R9 requests dropped in self-refresh
    cnt = 0; busy_n = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (cmd_auto) cnt++;
      if (bus_busy && in_sr && !acc_grant) busy_n++;
    end
    chk(cnt == 0, "R9", cnt, 0);
    chk(busy_n == 60, "R9", busy_n, 60);

    // R10 exit by clearing the mode bit
    wr_cfg(3'b100);
    chk(!cmd_sr_exit, "R10", cmd_sr_exit, 0);
    @(negedge clk);
    chk(cmd_sr_exit, "R10", cmd_sr_exit, 1);
    busy_n = 0; cnt = 0;
    for (int i = 0; i < RCL + 2; i++) begin
      if (bus_busy) busy_n++;
      if (cmd_sr_exit) cnt++;
      @(negedge clk);
    end
    chk(busy_n == RCL && cnt == 1, "R10", busy_n, RCL);
    wait_auto(200, n);
    chk(n > 0, "R10", n, 1);

    // R10 exit by clearing the enable bit
    repeat (RCL + 1) @(negedge clk);
    wr_cfg(3'b110);
    @(negedge clk);
    chk(cmd_sr_enter, "R8", cmd_sr_enter, 1);
    repeat (5) @(negedge clk);
    wr_cfg(3'b010);
    @(negedge clk);
    chk(cmd_sr_exit, "R10", cmd_sr_exit, 1);
    repeat (RCL) @(negedge clk);
    chk(!bus_busy && !in_sr, "R10", bus_busy, 0);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cmd_auto || cmd_sr_enter || cmd_sr_exit) cnt++;
    end
    chk(cnt == 0, "R4", cnt, 0);

    finish_run();
  end
endmodule